// File: doc/BRIEF.md
# Signed Two's Complement Array Multiplier

This block multiplies two N-bit two's complement numbers and returns their full 2N-bit signed product. It has no clock and no state: the product follows the operands through combinational logic. It is meant for datapaths that need an exact signed product in one cycle and can afford a regular array of adder cells in place of a tree.

Sign handling is folded into the array itself. Each partial-product bit is an AND of one operand bit with another. A bit that pairs exactly one sign bit with a non-sign bit enters inverted, through a NAND. Two constant ones are then injected into the sum. Because of this, every row is added with ordinary full adders and no row is sign-extended or subtracted. A grid of carry-save rows reduces the N partial-product rows to a sum vector and a carry vector. A ripple row turns the upper half into binary. The lower half of the product falls straight out of the array.

Top module: `bw_signed_mult`

## Requirements
- R1: For every pair of N-bit two's complement operands, the 2N-bit output equals the exact signed product x_i × y_i, read as a 2N-bit two's complement value, within the same cycle the operands are applied.
- R2: When either operand is zero, every bit of p_o is 0.
- R3: When both operands are the most negative value (only bit N-1 set), p_o has only bit 2N-2 set, and bit 2N-1 is 0.
- R4: Whenever the product is nonzero, the top bit of p_o (bit 2N-1) equals the XOR of the two operand sign bits (bit N-1 of each).
- R5: When one operand is +1, p_o is the other operand sign-extended to 2N bits.
- R6: When y_i is all ones (-1), p_o is the two's complement negation of x_i sign-extended to 2N bits. This includes x_i at the most negative value, which gives +2^(N-1).
- R7: The same description meets R1 with N set to 4, 8, 16 or 32. N must be at least 2.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | N | Multiplicand, two's complement |
| y_i | input | N | Multiplier, two's complement |
| p_o | output | 2N | Signed product, two's complement |

## Verification
A wrong internal state here means a flipped or misplaced partial-product bit, a missing correction one, or a carry dropped between cells. Each of these shows up in the same cycle as an error at p_o. The error is a signed multiple of one power of two, fixed by the column of the fault. Exhaustive pairs at N = 4 and N = 8 drive every cell with every input combination its position can see. The extreme operands (zero, ±1, the most negative and most positive values) reach the corrected sign columns and the top carry at every width.

// File: rtl/bw_mult_pkg.sv
`timescale 1ns/1ps
package bw_mult_pkg;

  // Classification of a partial-product bit by how many sign bits it pairs.
  typedef enum logic [1:0] {
    PP_PLAIN  = 2'd0,  // neither operand bit is a sign bit
    PP_CROSS  = 2'd1,  // exactly one is a sign bit: enters inverted
    PP_SIGNSQ = 2'd2   // both are sign bits: positive weight
  } pp_kind_e;

  function automatic pp_kind_e pp_kind(input int row, input int col, input int n);
    logic row_sign;
    logic col_sign;
    row_sign = (row == n - 1);
    col_sign = (col == n - 1);
    if (row_sign && col_sign) return PP_SIGNSQ;
    if (row_sign ^ col_sign)  return PP_CROSS;
    return PP_PLAIN;
  endfunction

endpackage

// File: rtl/bw_full_adder.sv
`timescale 1ns/1ps
module bw_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  logic half_s;

  assign half_s = a_i ^ b_i;
  assign s_o    = half_s ^ c_i;
  assign c_o    = (a_i & b_i) | (half_s & c_i);

endmodule

// File: rtl/bw_pp_gen.sv
`timescale 1ns/1ps
module bw_pp_gen
  import bw_mult_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]        mcand_i,
  input  logic [N-1:0]        mplier_i,
  output logic [N-1:0][N-1:0] pp_o      // pp_o[row][col], weight 2^(row+col)
);

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      localparam pp_kind_e KIND = pp_kind(r, c, N);
      if (KIND == PP_CROSS) begin : g_nand
        assign pp_o[r][c] = ~(mcand_i[c] & mplier_i[r]);
      end else begin : g_and
        assign pp_o[r][c] = mcand_i[c] & mplier_i[r];
      end
    end
  end

endmodule

// File: rtl/bw_csa_array.sv
`timescale 1ns/1ps
module bw_csa_array #(
  parameter int N = 8
) (
  input  logic [N-1:0][N-1:0] pp_i,
  output logic [N-1:0]        low_o,     // product bits 0..N-1
  output logic [N-2:0]        sum_hi_o,  // weights N..2N-2
  output logic [N-1:0]        carry_hi_o // weights N..2N-1
);

  // s_row[r][c] has weight 2^(r+c); c_row[r][c] has weight 2^(r+c+1).
  logic [N-1:0][N-1:0] s_row;
  logic [N-1:0][N-1:0] c_row;

  assign s_row[0] = pp_i[0];
  assign c_row[0] = '0;

  for (genvar r = 1; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      logic b_in;
      if (c == N - 1) begin : g_edge
        // Left edge: row 1 carries the correction one at weight 2^N.
        if (r == 1) begin : g_corr
          assign b_in = 1'b1;
        end else begin : g_zero
          assign b_in = 1'b0;
        end
      end else begin : g_inner
        assign b_in = s_row[r-1][c+1];
      end

      bw_full_adder u_fa (
        .a_i (pp_i[r][c]),
        .b_i (b_in),
        .c_i (c_row[r-1][c]),
        .s_o (s_row[r][c]),
        .c_o (c_row[r][c])
      );
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_low
    assign low_o[r] = s_row[r][0];
  end

  assign sum_hi_o   = s_row[N-1][N-1:1];
  assign carry_hi_o = c_row[N-1];

endmodule

// File: rtl/bw_ripple_row.sv
`timescale 1ns/1ps
module bw_ripple_row #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o   // modulo 2^W, carry out discarded
);

  logic [W-1:0] cy;

  assign cy[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_bit
    if (k == W - 1) begin : g_top
      assign sum_o[k] = a_i[k] ^ b_i[k] ^ cy[k];
    end else begin : g_cell
      bw_full_adder u_fa (
        .a_i (a_i[k]),
        .b_i (b_i[k]),
        .c_i (cy[k]),
        .s_o (sum_o[k]),
        .c_o (cy[k+1])
      );
    end
  end

endmodule

// File: rtl/bw_signed_mult.sv
`timescale 1ns/1ps
module bw_signed_mult #(
  parameter int N = 8
) (
  input  logic [N-1:0]   x_i,
  input  logic [N-1:0]   y_i,
  output logic [2*N-1:0] p_o
);

  localparam int PW = 2 * N;

  logic [N-1:0][N-1:0] pp;
  logic [N-1:0]        low;
  logic [N-2:0]        sum_hi;
  logic [N-1:0]        carry_hi;
  logic [N-1:0]        top_a;
  logic [N-1:0]        top_sum;

  bw_pp_gen #(.N(N)) u_pp (
    .mcand_i  (x_i),
    .mplier_i (y_i),
    .pp_o     (pp)
  );

  bw_csa_array #(.N(N)) u_array (
    .pp_i       (pp),
    .low_o      (low),
    .sum_hi_o   (sum_hi),
    .carry_hi_o (carry_hi)
  );

  // Second correction one sits at weight 2^(2N-1), the top bit of this row.
  assign top_a = {1'b1, sum_hi};

  bw_ripple_row #(.W(N)) u_final (
    .a_i   (top_a),
    .b_i   (carry_hi),
    .sum_o (top_sum)
  );

  assign p_o = {top_sum, low};

  if (PW != 2 * N) begin : g_never
    $error("bw_signed_mult: width mismatch");
  end

endmodule

// File: rtl/bw_signed_mult_chk.sv
`timescale 1ns/1ps
module bw_signed_mult_chk #(
  parameter int N = 8
) (
  input logic [N-1:0]   x_i,
  input logic [N-1:0]   y_i,
  input logic [2*N-1:0] p_o
);

  localparam int W = 2 * N;
  localparam logic [N-1:0] MOST_NEG = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] ONE_N    = {{(N-1){1'b0}}, 1'b1};

  logic signed [W-1:0] xe;
  logic signed [W-1:0] ye;
  logic signed [W-1:0] ref_p;

  always_comb begin
    xe    = {{N{x_i[N-1]}}, x_i};
    ye    = {{N{y_i[N-1]}}, y_i};
    ref_p = xe * ye;

    assert_exact_product_R1: assert (p_o == ref_p)
      else $error("R1 product mismatch");

    if (x_i == '0 || y_i == '0) begin
      assert_zero_operand_R2: assert (p_o == '0)
        else $error("R2 zero operand gave nonzero product");
    end

    if (x_i == MOST_NEG && y_i == MOST_NEG) begin
      assert_min_square_R3: assert (p_o == (W'(1) << (W - 2)))
        else $error("R3 most-negative square wrong");
    end

    if (p_o != '0) begin
      assert_sign_R4: assert (p_o[W-1] == (x_i[N-1] ^ y_i[N-1]))
        else $error("R4 product sign wrong");
    end

    if (y_i == ONE_N) begin
      assert_unit_y_R5: assert (p_o == xe)
        else $error("R5 times one wrong");
    end
    if (x_i == ONE_N) begin
      assert_unit_x_R5: assert (p_o == ye)
        else $error("R5 one times wrong");
    end

    if (y_i == '1) begin
      assert_negate_R6: assert (p_o == -xe)
        else $error("R6 times minus one wrong");
    end
  end

endmodule

bind bw_signed_mult bw_signed_mult_chk #(.N(N)) u_chk (
  .x_i (x_i),
  .y_i (y_i),
  .p_o (p_o)
);

// File: tb/bw_signed_mult_test.sv
`timescale 1ns/1ps
module bw_signed_mult_test;

  logic clk;
  logic rst_n;

  logic [3:0]  x4,  y4;   logic [7:0]  p4;
  logic [7:0]  x8,  y8;   logic [15:0] p8;
  logic [15:0] x16, y16;  logic [31:0] p16;
  logic [31:0] x32, y32;  logic [63:0] p32;

  bw_signed_mult #(.N(8))  uut    (.x_i(x8),  .y_i(y8),  .p_o(p8));
  bw_signed_mult #(.N(4))  uut_n4 (.x_i(x4),  .y_i(y4),  .p_o(p4));
  bw_signed_mult #(.N(16)) uut_n16(.x_i(x16), .y_i(y16), .p_o(p16));
  bw_signed_mult #(.N(32)) uut_n32(.x_i(x32), .y_i(y32), .p_o(p32));

  typedef struct {
    longint a4, b4, a8, b8, a16, b16, a32, b32;
  } item_t;

  item_t q[$];
  int checks   = 0;
  int failures = 0;
  int wfail4 = 0, wfail8 = 0, wfail16 = 0, wfail32 = 0;
  bit done     = 0;
  bit reported = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic longint sx(input longint v, input int n);
    longint t;
    t = v << (64 - n);
    return t >>> (64 - n);
  endfunction

  function automatic longint ext_val(input int k, input int n);
    longint mn;
    mn = -(longint'(1) << (n - 1));
    case (k)
      0:       return 0;
      1:       return 1;
      2:       return -1;
      3:       return mn;
      4:       return -mn - 1;
      default: return mn + 1;
    endcase
  endfunction

  task automatic note_fail(input int n);
    failures++;
    case (n)
      4:       wfail4++;
      8:       wfail8++;
      16:      wfail16++;
      default: wfail32++;
    endcase
  endtask

  task automatic check_one(input int n, input longint a, input longint b,
                           input logic [63:0] praw);
    longint xa, yb, exp_p, mask, got;
    string tag;
    xa    = sx(a, n);
    yb    = sx(b, n);
    exp_p = xa * yb;
    mask  = (n >= 32) ? -longint'(1) : ((longint'(1) << (2 * n)) - 1);
    got   = longint'(praw) & mask;
    if (xa == 0 || yb == 0)                                   tag = "R2";
    else if (xa == -(longint'(1) << (n - 1)) && xa == yb)     tag = "R3";
    else if (xa == 1 || yb == 1)                              tag = "R5";
    else if (yb == -1)                                        tag = "R6";
    else                                                      tag = "R1";
    checks++;
    if (got != (exp_p & mask)) begin
      note_fail(n);
      $display("FAIL %s N=%0d x=%0d y=%0d actual=%h expected=%h",
               tag, n, xa, yb, got, exp_p & mask);
    end
    if (exp_p != 0) begin
      checks++;
      if (praw[2*n-1] != (exp_p < 0)) begin
        note_fail(n);
        $display("FAIL R4 N=%0d x=%0d y=%0d actual_sign=%0b expected_sign=%0b",
                 n, xa, yb, praw[2*n-1], exp_p < 0);
      end
    end
  endtask

  task automatic drive(input longint a4, input longint b4, input longint a8,
                       input longint b8, input longint a16, input longint b16,
                       input longint a32, input longint b32);
    item_t it;
    @(posedge clk);
    #1;
    x4 = a4[3:0];    y4 = b4[3:0];
    x8 = a8[7:0];    y8 = b8[7:0];
    x16 = a16[15:0]; y16 = b16[15:0];
    x32 = a32[31:0]; y32 = b32[31:0];
    it.a4 = a4;   it.b4 = b4;   it.a8 = a8;   it.b8 = b8;
    it.a16 = a16; it.b16 = b16; it.a32 = a32; it.b32 = b32;
    q.push_back(it);
  endtask

  // Monitor: one scoreboard item per cycle, compared half a cycle later.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check_one(4,  it.a4,  it.b4,  {56'd0, p4});
        check_one(8,  it.a8,  it.b8,  {48'd0, p8});
        check_one(16, it.a16, it.b16, {32'd0, p16});
        check_one(32, it.a32, it.b32, p32);
      end
    end
  end

  task automatic report;
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
    end
  end

  initial begin
    rst_n = 1'b0;
    x4 = '0; y4 = '0; x8 = '0; y8 = '0;
    x16 = '0; y16 = '0; x32 = '0; y32 = '0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;

    // Reset state: zero operands give a zero product (R2).
    @(negedge clk);
    checks++;
    if (p4 != '0 || p8 != '0 || p16 != '0 || p32 != '0) begin
      failures++;
      $display("FAIL R2 reset state actual=%h/%h/%h/%h expected=0",
               p4, p8, p16, p32);
    end

    // Exhaustive at N=8 (and N=4 repeatedly), random at N=16/32 (R1).
    for (int i = 0; i < 65536; i++) begin
      longint r16a, r16b, r32a, r32b;
      r16a = longint'($urandom);
      r16b = longint'($urandom);
      r32a = longint'($urandom);
      r32b = longint'($urandom);
      drive(longint'(i[7:4]), longint'(i[3:0]),
            longint'(i[15:8]), longint'(i[7:0]),
            r16a, r16b, r32a, r32b);
    end

    // Extreme values at every width: R2, R3, R5, R6 corners.
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        drive(ext_val(i, 4),  ext_val(j, 4),  ext_val(i, 8),  ext_val(j, 8),
              ext_val(i, 16), ext_val(j, 16), ext_val(i, 32), ext_val(j, 32));
      end
    end

    repeat (3) @(posedge clk);
    @(negedge clk);

    // R7: each width instance produced no failures.
    checks++; if (wfail4  != 0) $display("FAIL R7 N=4 actual=%0d expected=0",  wfail4);
    checks++; if (wfail8  != 0) $display("FAIL R7 N=8 actual=%0d expected=0",  wfail8);
    checks++; if (wfail16 != 0) $display("FAIL R7 N=16 actual=%0d expected=0", wfail16);
    checks++; if (wfail32 != 0) $display("FAIL R7 N=32 actual=%0d expected=0", wfail32);
    if (wfail4 != 0)  failures++;
    if (wfail8 != 0)  failures++;
    if (wfail16 != 0) failures++;
    if (wfail32 != 0) failures++;

    done = 1;
    report();
  end

endmodule